// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block stores the five-entry, 64-bit-per-entry frame that an interrupt or exception leaves on the current stack when the handler runs without a stack switch. It also works out the architectural state the handler starts with. A start pulse captures a context:

- the stack pointer;
- the address of the instruction that was interrupted;
- the code and stack selectors;
- the flags word;
- the gate kind (interrupt or trap);
- the current privilege level, the target privilege level and the alternate-stack index.

The block computes an aligned frame base. It checks with two probe requests that the lowest and highest entries of the frame are reachable. It then pushes the five entries one per accepted write handshake. On the last accepted write it commits the new stack pointer, stack selector and flags together.

Two cases need a stack switch, which this block does not perform: a nonzero alternate-stack index, and a change of privilege level. In either case the block answers with an "unsupported" pulse and performs no memory traffic. With that pulse it reports which case applied and the stack selector that a switching path should use. A failed probe raises a fault pulse and leaves every committed output untouched.

Top module: `irq_frame_pusher`

## Requirements
- R1: The frame base is the start stack pointer minus 40, with its low ALIGN_LOG2 bits (4 by default) cleared. Subtraction wraps modulo 2^ADDR_W. This base becomes `arch_rsp` when the frame completes.
- R2: Two probe requests come before any write. The first probe is at the base and the second at base+32. Each probe is held with a stable address until `probe_ack`. Probes and writes are never requested in the same cycle.
- R3: A probe answered with `probe_ack`=1 and `probe_ok`=0 gives a one-cycle `fault` pulse in the next cycle. The block is then idle with no write issued, and `arch_rsp`, `arch_ss` and `arch_flags` keep their values.
- R4: Exactly five writes follow, at base+0, +8, +16, +24 and +32 in that order. Each write advances only on a cycle with `wr_valid` and `wr_ready` both high. Address and data stay stable while `wr_ready` is low.
- R5: The write data is as follows:
  - +0: the interrupted instruction's own address (`cur_ip`);
  - +8: the code selector, zero-extended;
  - +16: the flags word as it was at start;
  - +24: the stack pointer as it was at start;
  - +32: the stack selector, zero-extended.
- R6: The committed flags are the start flags with bits 8, 14 and 16 cleared. Bit 9 is cleared when `gate_trap`=0 (interrupt gate) and kept when `gate_trap`=1 (trap gate). All other bits are unchanged.
- R7: `done` pulses for one cycle, in the cycle after the fifth write is accepted. In that same cycle `arch_rsp`, `arch_ss` (the start stack selector) and `arch_flags` all take their new values. These three outputs change in no other cycle.
- R8: With `ist_idx` nonzero at start, the block pulses `unsup` in the next cycle with `unsup_ist`=1. It issues no probe and no write. This case takes priority over a privilege change.
- R9: When `gate_dpl` differs from `cur_cpl`, the recorded stack selector `switch_ss` is forced to zero; otherwise it equals `ss_sel`. With `ist_idx`=0, a privilege difference gives the `unsup` pulse with `unsup_ist`=0 and no memory traffic.
- R10: A start pulse while a frame is in progress is ignored. Changed inputs during the frame alter neither the writes nor the committed values, and no further request follows the completion.
- R11: After reset:
  - `done`, `fault`, `unsup`, `probe_req` and `wr_valid` are low;
  - `arch_rsp`, `arch_ss` and `arch_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame; takes effect only when idle |
| cur_rsp | input | ADDR_W | Stack pointer at start |
| cur_ip | input | ADDR_W | Address of the interrupted instruction |
| cs_sel | input | SEL_W | Current code selector |
| ss_sel | input | SEL_W | Current stack selector |
| cur_flags | input | SLOT_W | Flags word at start |
| gate_trap | input | 1 | Gate kind: 1 trap, 0 interrupt |
| cur_cpl | input | PRIV_W | Current privilege level |
| gate_dpl | input | PRIV_W | Target privilege level |
| ist_idx | input | IST_W | Alternate-stack index of the gate |
| probe_req | output | 1 | Probe request |
| probe_addr | output | ADDR_W | Probe address |
| probe_ack | input | 1 | Probe answered |
| probe_ok | input | 1 | Probe result, valid with probe_ack |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | SLOT_W | Write data |
| wr_ready | input | 1 | Write accepted |
| done | output | 1 | Frame complete pulse |
| fault | output | 1 | Probe failure pulse |
| unsup | output | 1 | Stack switch needed, not performed |
| unsup_ist | output | 1 | Reason with last unsup: 1 alternate stack, 0 privilege change |
| switch_ss | output | SEL_W | Recorded stack selector with last unsup |
| arch_rsp | output | ADDR_W | Committed stack pointer |
| arch_ss | output | SEL_W | Committed stack selector |
| arch_flags | output | SLOT_W | Committed flags |

## Verification
The bench builds the block with its defaults: 64-bit addresses and entries, 16-bit selectors, 2-bit privilege levels, a 3-bit stack index and 16-byte alignment. At full width, a stack pointer just above zero wraps the base to the top of the address space. A flags word of all ones shows that only the four named bits move. Both the aligned and the unaligned starting pointer are exercised. Stalls on the probe and write handshakes, together with a start pulse injected mid-frame, show the hold and ignore rules.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;

   localparam int FRAME_SLOTS = 5;

   localparam int SLOT_IP  = 0;
   localparam int SLOT_CS  = 1;
   localparam int SLOT_FLG = 2;
   localparam int SLOT_SP  = 3;
   localparam int SLOT_SS  = 4;

   localparam int FLG_TRAPSTEP = 8;
   localparam int FLG_INTEN    = 9;
   localparam int FLG_NESTED   = 14;
   localparam int FLG_RESUME   = 16;

   typedef enum logic [1:0] {
      PS_IDLE     = 2'd0,
      PS_PROBE_LO = 2'd1,
      PS_PROBE_HI = 2'd2,
      PS_PUSH     = 2'd3
   } push_state_e;

endpackage

// File: rtl/irq_frame_geom.sv
module irq_frame_geom
   import irq_frame_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int SLOT_BYTES = 8,
   parameter int ALIGN_LOG2 = 4,
   parameter int IDX_W      = 3
) (
   input  logic [ADDR_W-1:0] rsp_i,
   input  logic [ADDR_W-1:0] base_q_i,
   input  logic              probe_hi_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] probe_addr_o,
   output logic [ADDR_W-1:0] wr_addr_o
);
   localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);
   localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(FRAME_SLOTS * SLOT_BYTES);
   localparam logic [ADDR_W-1:0] TOP_OFF     = ADDR_W'((FRAME_SLOTS - 1) * SLOT_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK  = ~((ADDR_W'(1) << ALIGN_LOG2) - ADDR_W'(1));

   logic [ADDR_W-1:0] raw_base;
   logic [ADDR_W-1:0] idx_ext;

   assign raw_base     = rsp_i - FRAME_BYTES;
   assign base_o       = raw_base & ALIGN_MASK;
   assign probe_addr_o = probe_hi_i ? (base_q_i + TOP_OFF) : base_q_i;
   assign idx_ext      = {{(ADDR_W-IDX_W){1'b0}}, idx_i};
   assign wr_addr_o    = base_q_i + (idx_ext << SLOT_SHIFT);

endmodule

// File: rtl/irq_frame_flags.sv
module irq_frame_flags
   import irq_frame_pkg::*;
#(
   parameter int FLAG_W = 64
) (
   input  logic [FLAG_W-1:0] flags_i,
   input  logic              trap_gate_i,
   output logic [FLAG_W-1:0] flags_o
);
   always_comb begin
      flags_o               = flags_i;
      flags_o[FLG_TRAPSTEP] = 1'b0;
      flags_o[FLG_NESTED]   = 1'b0;
      flags_o[FLG_RESUME]   = 1'b0;
      flags_o[FLG_INTEN]    = flags_i[FLG_INTEN] & trap_gate_i;
   end

endmodule

// File: rtl/irq_frame_slots.sv
module irq_frame_slots
   import irq_frame_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int SLOT_W = 64,
   parameter int SEL_W  = 16,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] ip_i,
   input  logic [SEL_W-1:0]  cs_i,
   input  logic [SLOT_W-1:0] flags_i,
   input  logic [ADDR_W-1:0] rsp_i,
   input  logic [SEL_W-1:0]  ss_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [SLOT_W-1:0] data_o
);
   logic [SLOT_W-1:0] slot [FRAME_SLOTS];
   logic [SLOT_W-1:0] cs_ext, ss_ext, ip_ext, rsp_ext;

   generate
      if (SEL_W == SLOT_W) begin : g_sel_same
         assign cs_ext = cs_i;
         assign ss_ext = ss_i;
      end else begin : g_sel_zext
         assign cs_ext = {{(SLOT_W-SEL_W){1'b0}}, cs_i};
         assign ss_ext = {{(SLOT_W-SEL_W){1'b0}}, ss_i};
      end
      if (ADDR_W == SLOT_W) begin : g_addr_same
         assign ip_ext  = ip_i;
         assign rsp_ext = rsp_i;
      end else begin : g_addr_zext
         assign ip_ext  = {{(SLOT_W-ADDR_W){1'b0}}, ip_i};
         assign rsp_ext = {{(SLOT_W-ADDR_W){1'b0}}, rsp_i};
      end
   endgenerate

   assign slot[SLOT_IP]  = ip_ext;
   assign slot[SLOT_CS]  = cs_ext;
   assign slot[SLOT_FLG] = flags_i;
   assign slot[SLOT_SP]  = rsp_ext;
   assign slot[SLOT_SS]  = ss_ext;

   always_comb begin
      data_o = '0;
      for (int k = 0; k < FRAME_SLOTS; k++) begin
         if (idx_i == IDX_W'(k)) data_o = slot[k];
      end
   end

endmodule

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
   import irq_frame_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             need_switch_i,
   input  logic             probe_ack_i,
   input  logic             probe_ok_i,
   input  logic             wr_ready_i,
   output logic             accept_o,
   output logic             commit_o,
   output logic             probe_req_o,
   output logic             probe_hi_o,
   output logic             wr_valid_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o,
   output logic             fault_o,
   output logic             unsup_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_SLOTS - 1);

   push_state_e state_q;
   logic [IDX_W-1:0] idx_q;
   logic done_q, fault_q, unsup_q;

   assign accept_o    = (state_q == PS_IDLE) && start_i;
   assign probe_req_o = (state_q == PS_PROBE_LO) || (state_q == PS_PROBE_HI);
   assign probe_hi_o  = (state_q == PS_PROBE_HI);
   assign wr_valid_o  = (state_q == PS_PUSH);
   assign commit_o    = (state_q == PS_PUSH) && wr_ready_i && (idx_q == LAST_IDX);
   assign idx_o       = idx_q;
   assign done_o      = done_q;
   assign fault_o     = fault_q;
   assign unsup_o     = unsup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unsup_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unsup_q <= 1'b0;
         case (state_q)
            PS_IDLE: begin
               if (start_i) begin
                  if (need_switch_i) unsup_q <= 1'b1;
                  else               state_q <= PS_PROBE_LO;
               end
            end
            PS_PROBE_LO: begin
               if (probe_ack_i) begin
                  if (probe_ok_i) state_q <= PS_PROBE_HI;
                  else begin
                     fault_q <= 1'b1;
                     state_q <= PS_IDLE;
                  end
               end
            end
            PS_PROBE_HI: begin
               if (probe_ack_i) begin
                  if (probe_ok_i) begin
                     idx_q   <= '0;
                     state_q <= PS_PUSH;
                  end else begin
                     fault_q <= 1'b1;
                     state_q <= PS_IDLE;
                  end
               end
            end
            PS_PUSH: begin
               if (wr_ready_i) begin
                  if (idx_q == LAST_IDX) begin
                     done_q  <= 1'b1;
                     state_q <= PS_IDLE;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            default: state_q <= PS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/irq_frame_pusher.sv
module irq_frame_pusher
   import irq_frame_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int SLOT_W     = 64,
   parameter int SEL_W      = 16,
   parameter int PRIV_W     = 2,
   parameter int IST_W      = 3,
   parameter int ALIGN_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cur_rsp,
   input  logic [ADDR_W-1:0] cur_ip,
   input  logic [SEL_W-1:0]  cs_sel,
   input  logic [SEL_W-1:0]  ss_sel,
   input  logic [SLOT_W-1:0] cur_flags,
   input  logic              gate_trap,
   input  logic [PRIV_W-1:0] cur_cpl,
   input  logic [PRIV_W-1:0] gate_dpl,
   input  logic [IST_W-1:0]  ist_idx,
   output logic              probe_req,
   output logic [ADDR_W-1:0] probe_addr,
   input  logic              probe_ack,
   input  logic              probe_ok,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [SLOT_W-1:0] wr_data,
   input  logic              wr_ready,
   output logic              done,
   output logic              fault,
   output logic              unsup,
   output logic              unsup_ist,
   output logic [SEL_W-1:0]  switch_ss,
   output logic [ADDR_W-1:0] arch_rsp,
   output logic [SEL_W-1:0]  arch_ss,
   output logic [SLOT_W-1:0] arch_flags
);
   localparam int SLOT_BYTES = SLOT_W / 8;
   localparam int IDX_W      = $clog2(FRAME_SLOTS);

   generate
      if (SLOT_W < FLG_RESUME + 1 || (SLOT_W % 8) != 0) begin : g_bad_slot_w
         initial $fatal(1, "irq_frame_pusher: SLOT_W must be a byte multiple wide enough for the flag bits");
      end
      if ((1 << $clog2(SLOT_BYTES)) != SLOT_BYTES) begin : g_bad_slot_pow2
         initial $fatal(1, "irq_frame_pusher: SLOT_W/8 must be a power of two");
      end
      if (SEL_W > SLOT_W || ADDR_W > SLOT_W) begin : g_bad_ext
         initial $fatal(1, "irq_frame_pusher: selectors and addresses must fit in one slot");
      end
      if (ALIGN_LOG2 >= ADDR_W || PRIV_W < 1 || IST_W < 1) begin : g_bad_misc
         initial $fatal(1, "irq_frame_pusher: illegal alignment or field width");
      end
   endgenerate

   logic [ADDR_W-1:0] ctx_base, ctx_ip, ctx_rsp;
   logic [SEL_W-1:0]  ctx_cs, ctx_ss;
   logic [SLOT_W-1:0] ctx_flags;
   logic              ctx_trap;
   logic              unsup_ist_q;
   logic [SEL_W-1:0]  switch_ss_q;
   logic [ADDR_W-1:0] arch_rsp_q;
   logic [SEL_W-1:0]  arch_ss_q;
   logic [SLOT_W-1:0] arch_flags_q;

   logic              priv_change, ist_req, need_switch;
   logic              accept, commit, probe_hi;
   logic [IDX_W-1:0]  slot_idx;
   logic [ADDR_W-1:0] new_base;
   logic [SLOT_W-1:0] new_flags;

   assign priv_change = (cur_cpl != gate_dpl);
   assign ist_req     = (ist_idx != '0);
   assign need_switch = priv_change || ist_req;

   irq_frame_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .need_switch_i(need_switch),
      .probe_ack_i  (probe_ack),
      .probe_ok_i   (probe_ok),
      .wr_ready_i   (wr_ready),
      .accept_o     (accept),
      .commit_o     (commit),
      .probe_req_o  (probe_req),
      .probe_hi_o   (probe_hi),
      .wr_valid_o   (wr_valid),
      .idx_o        (slot_idx),
      .done_o       (done),
      .fault_o      (fault),
      .unsup_o      (unsup)
   );

   irq_frame_geom #(
      .ADDR_W    (ADDR_W),
      .SLOT_BYTES(SLOT_BYTES),
      .ALIGN_LOG2(ALIGN_LOG2),
      .IDX_W     (IDX_W)
   ) u_geom (
      .rsp_i       (cur_rsp),
      .base_q_i    (ctx_base),
      .probe_hi_i  (probe_hi),
      .idx_i       (slot_idx),
      .base_o      (new_base),
      .probe_addr_o(probe_addr),
      .wr_addr_o   (wr_addr)
   );

   irq_frame_slots #(
      .ADDR_W(ADDR_W),
      .SLOT_W(SLOT_W),
      .SEL_W (SEL_W),
      .IDX_W (IDX_W)
   ) u_slots (
      .ip_i   (ctx_ip),
      .cs_i   (ctx_cs),
      .flags_i(ctx_flags),
      .rsp_i  (ctx_rsp),
      .ss_i   (ctx_ss),
      .idx_i  (slot_idx),
      .data_o (wr_data)
   );

   irq_frame_flags #(.FLAG_W(SLOT_W)) u_flags (
      .flags_i    (ctx_flags),
      .trap_gate_i(ctx_trap),
      .flags_o    (new_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_base    <= '0;
         ctx_ip      <= '0;
         ctx_rsp     <= '0;
         ctx_cs      <= '0;
         ctx_ss      <= '0;
         ctx_flags   <= '0;
         ctx_trap    <= 1'b0;
         unsup_ist_q <= 1'b0;
         switch_ss_q <= '0;
      end else if (accept) begin
         ctx_base  <= new_base;
         ctx_ip    <= cur_ip;
         ctx_rsp   <= cur_rsp;
         ctx_cs    <= cs_sel;
         ctx_ss    <= ss_sel;
         ctx_flags <= cur_flags;
         ctx_trap  <= gate_trap;
         if (need_switch) begin
            unsup_ist_q <= ist_req;
            switch_ss_q <= priv_change ? '0 : ss_sel;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arch_rsp_q   <= '0;
         arch_ss_q    <= '0;
         arch_flags_q <= '0;
      end else if (commit) begin
         arch_rsp_q   <= ctx_base;
         arch_ss_q    <= ctx_ss;
         arch_flags_q <= new_flags;
      end
   end

   assign unsup_ist  = unsup_ist_q;
   assign switch_ss  = switch_ss_q;
   assign arch_rsp   = arch_rsp_q;
   assign arch_ss    = arch_ss_q;
   assign arch_flags = arch_flags_q;

endmodule

// File: rtl/irq_frame_pusher_chk.sv
module irq_frame_pusher_chk
   import irq_frame_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int SLOT_W     = 64,
   parameter int SEL_W      = 16,
   parameter int ALIGN_LOG2 = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              probe_req,
   input logic [ADDR_W-1:0] probe_addr,
   input logic              probe_ack,
   input logic              probe_ok,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [SLOT_W-1:0] wr_data,
   input logic              wr_ready,
   input logic              done,
   input logic              fault,
   input logic              unsup,
   input logic [ADDR_W-1:0] arch_rsp,
   input logic [SEL_W-1:0]  arch_ss,
   input logic [SLOT_W-1:0] arch_flags
);
   localparam int SLOT_SHIFT = $clog2(SLOT_W / 8);

   AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_req && !probe_ack) |=> (probe_req && $stable(probe_addr))); // R2

   AST_PROBE_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(probe_req && wr_valid)); // R2

   AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R4

   AST_WRITE_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr[SLOT_SHIFT-1:0] == '0)); // R4

   AST_FAULT_FOLLOWS_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(probe_req && probe_ack && !probe_ok)); // R3

   AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_valid && wr_ready)); // R7

   AST_OUTCOME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault, unsup})); // R7

   AST_ARCH_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (arch_rsp != $past(arch_rsp) || arch_ss != $past(arch_ss) ||
       arch_flags != $past(arch_flags)) |-> done); // R7

   AST_RSP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (arch_rsp[ALIGN_LOG2-1:0] == '0)); // R1

   AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!arch_flags[FLG_TRAPSTEP] && !arch_flags[FLG_NESTED] && !arch_flags[FLG_RESUME])); // R6

endmodule

bind irq_frame_pusher irq_frame_pusher_chk #(
   .ADDR_W    (ADDR_W),
   .SLOT_W    (SLOT_W),
   .SEL_W     (SEL_W),
   .ALIGN_LOG2(ALIGN_LOG2)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .probe_req (probe_req),
   .probe_addr(probe_addr),
   .probe_ack (probe_ack),
   .probe_ok  (probe_ok),
   .wr_valid  (wr_valid),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .wr_ready  (wr_ready),
   .done      (done),
   .fault     (fault),
   .unsup     (unsup),
   .arch_rsp  (arch_rsp),
   .arch_ss   (arch_ss),
   .arch_flags(arch_flags)
);

// File: tb/irq_frame_pusher_tb_top.sv
module irq_frame_pusher_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] cur_rsp = '0, cur_ip = '0, cur_flags = '0;
   logic [15:0] cs_sel = '0, ss_sel = '0;
   logic        gate_trap = 1'b0;
   logic [1:0]  cur_cpl = '0, gate_dpl = '0;
   logic [2:0]  ist_idx = '0;
   logic        probe_ack = 1'b0, probe_ok = 1'b0, wr_ready = 1'b0;
   logic        probe_req, wr_valid, done, fault, unsup, unsup_ist;
   logic [63:0] probe_addr, wr_addr, wr_data, arch_rsp, arch_flags;
   logic [15:0] switch_ss, arch_ss;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [63:0] exp_rsp = '0, exp_flags = '0;
   logic [15:0] exp_ss = '0;

   always #2 clk = ~clk;

   irq_frame_pusher dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cur_rsp(cur_rsp), .cur_ip(cur_ip),
      .cs_sel(cs_sel), .ss_sel(ss_sel), .cur_flags(cur_flags), .gate_trap(gate_trap),
      .cur_cpl(cur_cpl), .gate_dpl(gate_dpl), .ist_idx(ist_idx),
      .probe_req(probe_req), .probe_addr(probe_addr), .probe_ack(probe_ack), .probe_ok(probe_ok),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .done(done), .fault(fault), .unsup(unsup), .unsup_ist(unsup_ist), .switch_ss(switch_ss),
      .arch_rsp(arch_rsp), .arch_ss(arch_ss), .arch_flags(arch_flags)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic chk_arch(input string tag);
      chk(arch_rsp,   exp_rsp,   {tag, " R1 R7 arch_rsp"});
      chk({48'd0, arch_ss}, {48'd0, exp_ss}, {tag, " R7 arch_ss"});
      chk(arch_flags, exp_flags, {tag, " R6 R7 arch_flags"});
   endtask

   function automatic logic [63:0] model_flags(input logic [63:0] f, input logic trap);
      logic [63:0] r;
      r = f;
      r[8] = 1'b0; r[14] = 1'b0; r[16] = 1'b0;
      if (!trap) r[9] = 1'b0;
      return r;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic run_frame(input logic [63:0] rsp, input logic [63:0] ip, input logic [63:0] flg,
                            input logic [15:0] cs, input logic [15:0] ss, input logic trap,
                            input logic [1:0] cpl, input logic [1:0] dpl, input logic [2:0] ist,
                            input int fail_at, input int stall, input bit poke, input string tag);
      logic [63:0] base;
      logic [63:0] slots[5];
      int probes, writes, wait_c;
      bit pend_done, pend_fault, fin, poked;
      base = (rsp - 64'd40) & ~64'hF;
      slots[0] = ip; slots[1] = {48'd0, cs}; slots[2] = flg; slots[3] = rsp; slots[4] = {48'd0, ss};
      @(negedge clk);
      cur_rsp = rsp; cur_ip = ip; cur_flags = flg; cs_sel = cs; ss_sel = ss;
      gate_trap = trap; cur_cpl = cpl; gate_dpl = dpl; ist_idx = ist; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (ist != 3'd0 || cpl != dpl) begin
         chk({63'd0, unsup}, 64'd1, {tag, " R8 R9 unsup pulse"});
         chk({63'd0, unsup_ist}, {63'd0, (ist != 3'd0)}, {tag, " R8 unsup_ist priority"});
         chk({48'd0, switch_ss}, (cpl != dpl) ? 64'd0 : {48'd0, ss}, {tag, " R9 switch_ss"});
         chk({63'd0, probe_req | wr_valid | done | fault}, 64'd0, {tag, " R8 R9 no traffic"});
         chk_arch(tag);
         @(negedge clk);
         chk({63'd0, unsup | probe_req | wr_valid}, 64'd0, {tag, " R8 R9 idle after unsup"});
         return;
      end
      probes = 0; writes = 0; wait_c = 0; poked = 0;
      pend_done = 0; pend_fault = 0; fin = 0;
      for (int c = 0; c < 80 && !fin; c++) begin
         chk({63'd0, done},  {63'd0, pend_done},  {tag, " R7 done timing"});
         chk({63'd0, fault}, {63'd0, pend_fault}, {tag, " R3 fault timing"});
         if (pend_done) begin
            exp_rsp = base; exp_ss = ss; exp_flags = model_flags(flg, trap);
         end
         chk_arch(tag);
         if (pend_done || pend_fault) begin
            fin = 1;
            chk(64'(writes), pend_done ? 64'd5 : 64'd0, {tag, " R2 R4 write count"});
         end
         pend_done = 0; pend_fault = 0;
         probe_ack = 1'b0; wr_ready = 1'b0; start = 1'b0;
         if (!fin) begin
            if (probe_req) begin
               chk(probe_addr, (probes == 0) ? base : base + 64'd32, {tag, " R2 probe address"});
               chk(64'(writes), 64'd0, {tag, " R2 no write before probes"});
               if (stall > 1 && wait_c == 0) wait_c = 1;
               else begin
                  wait_c = 0;
                  probe_ack = 1'b1;
                  probe_ok = (fail_at != probes + 1);
                  if (!probe_ok) pend_fault = 1;
                  probes++;
               end
            end
            if (wr_valid) begin
               chk(64'(probes), 64'd2, {tag, " R2 both probes first"});
               chk(wr_addr, base + 64'(writes * 8), {tag, " R4 write address"});
               chk(wr_data, slots[writes], {tag, " R5 write data"});
               if (poke && !poked && writes == 2) begin
                  poked = 1; start = 1'b1;
                  cur_rsp = rsp ^ 64'hF0F0; cur_ip = ~ip; cur_flags = ~flg; ss_sel = ~ss;
               end
               if (stall <= 1 || (c % stall) == 0) begin
                  wr_ready = 1'b1;
                  writes++;
                  if (writes == 5) pend_done = 1;
               end
            end
         end
         @(negedge clk);
      end
      probe_ack = 1'b0; wr_ready = 1'b0;
      if (!fin) chk(64'd0, 64'd1, {tag, " R7 frame completion"});
      chk({63'd0, probe_req | wr_valid | done | fault}, 64'd0, {tag, " R10 idle after frame"});
      chk_arch(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({59'd0, done, fault, unsup, probe_req, wr_valid}, 64'd0, "R11 reset outputs");
      chk(arch_rsp, 64'd0, "R11 reset arch_rsp");
      chk({48'd0, arch_ss}, 64'd0, "R11 reset arch_ss");
      chk(arch_flags, 64'd0, "R11 reset arch_flags");
      rst_n = 1'b1;
      @(negedge clk);
      chk({59'd0, done, fault, unsup, probe_req, wr_valid}, 64'd0, "R11 idle after reset");

      run_frame(64'h0000_7fff_ffff_e008, 64'hffff_8000_0010_2345, 64'h0000_0000_0005_4302,
                16'h0010, 16'h0018, 1'b1, 2'd0, 2'd0, 3'd0, 0, 1, 0, "trap gate");
      run_frame(64'h0000_0000_0020_1000, 64'h0000_0000_0040_0abc, 64'h0000_0000_0000_0246,
                16'h0033, 16'h002b, 1'b0, 2'd3, 2'd3, 3'd0, 0, 3, 0, "interrupt gate stalled");
      run_frame(64'h0000_0000_0000_0028, 64'h1234_5678_9abc_def0, 64'hffff_ffff_ffff_ffff,
                16'hfffc, 16'h8001, 1'b0, 2'd1, 2'd1, 3'd0, 0, 2, 0, "all flags");
      run_frame(64'h0000_0000_0000_0010, 64'h0000_0000_0000_0777, 64'hffff_ffff_ffff_ffff,
                16'h0008, 16'h0010, 1'b1, 2'd0, 2'd0, 3'd0, 0, 1, 0, "wrap below zero");
      run_frame(64'h0000_0000_0030_0000, 64'h0000_0000_0000_1111, 64'h0000_0000_0001_0200,
                16'h0010, 16'h0018, 1'b1, 2'd0, 2'd0, 3'd0, 1, 1, 0, "R3 low probe fails");
      run_frame(64'h0000_0000_0030_0000, 64'h0000_0000_0000_2222, 64'h0000_0000_0001_0200,
                16'h0010, 16'h0018, 1'b1, 2'd0, 2'd0, 3'd0, 2, 2, 0, "R3 high probe fails");
      run_frame(64'h0000_0000_0050_0000, 64'h0000_0000_0000_3333, 64'h0000_0000_0000_0202,
                16'h0023, 16'h002b, 1'b0, 2'd3, 2'd0, 3'd3, 0, 1, 0, "R8 ist with priv change");
      run_frame(64'h0000_0000_0050_0000, 64'h0000_0000_0000_4444, 64'h0000_0000_0000_0202,
                16'h0023, 16'h002b, 1'b0, 2'd2, 2'd2, 3'd1, 0, 1, 0, "R8 ist same priv");
      run_frame(64'h0000_0000_0050_0000, 64'h0000_0000_0000_5555, 64'h0000_0000_0000_0202,
                16'h0023, 16'h002b, 1'b0, 2'd3, 2'd0, 3'd0, 0, 1, 0, "R9 priv change");
      run_frame(64'h0000_0000_0060_0abc, 64'h0000_0000_0000_6666, 64'h0000_0000_0000_4302,
                16'h0010, 16'h0018, 1'b0, 2'd0, 2'd0, 3'd0, 0, 2, 1, "R10 start while busy");
      run_frame(64'h0000_0000_0070_0001, 64'h0000_0000_0000_7777, 64'h0000_0000_0001_4200,
                16'h0010, 16'h0018, 1'b1, 2'd0, 2'd0, 3'd0, 0, 1, 0, "recovery");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule